// File: doc/BRIEF.md
# DLL Power-Up Sequencer for a Synchronous SRAM Interface

This block sits on the controller side of a DLL-based synchronous SRAM link and takes the interface from power-on to the point where commands may be issued. It keeps the memory's DLL held off until two conditions hold: the supplies are reported good and the input clock is reported stable. It then releases the DLL and counts a fixed number of lock cycles. After that it counts a further run of cycles that contain no read, because the memory needs them to settle its output-driver impedance. When both counts are complete it raises a ready flag. The command scheduler uses that flag to gate issue.

Two events force the sequence to repeat. The first is a request to change the operating frequency. The second is the input clock losing stability once the DLL has been released. In both cases the sequencer asks for the clock to be halted for a minimum number of reference cycles while the DLL line stays released; this resets the DLL. Once the halt is over and the clock is stable again, it redoes the full lock count and the full calibration count. If power-good falls, the sequence returns to its starting point with the DLL held off.

Top module: `sram_dll_seq`

## Requirements
- R1: After reset, `dllEnable`, `clkStopReq` and `ready` are all low.
- R2: `dllEnable` stays low until the sequencer has seen `pwrGood` for at least one edge and then samples `clkStable` high. It rises on the edge that samples `clkStable` high, at the earliest on the second edge after `pwrGood` goes high.
- R3: After `dllEnable` rises, `ready` stays low for LOCK_CYCLES edges of lock counting followed by CAL_CYCLES edges of calibration counting. With no reads, it rises LOCK_CYCLES+CAL_CYCLES edges after `dllEnable` rises. A high `rdReq` during the lock count does not lengthen it.
- R4: The calibration count advances only on edges where `rdReq` is low. Each edge with `rdReq` high during calibration delays `ready` by one edge.
- R5: When `freqChange` is high during lock, calibration or ready, `ready` drops and `clkStopReq` rises on the next edge, while `dllEnable` stays high.
- R6: `clkStopReq` stays high for at least HALT_CYCLES edges and until `clkStable` is sampled high. The sequencer then restarts the lock count and the calibration count from zero, and calibration progress made before the halt is discarded.
- R7: When `clkStable` is low during lock, calibration or ready, the sequencer enters the clock-halt state on the next edge.
- R8: When `pwrGood` is low, all three outputs are low on the next edge, from any state. The sequence then starts again from the beginning.
- R9: `freqChange` has no effect while the DLL is still held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock; all counts are in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supplies reported stable |
| clkStable | input | 1 | Memory input clock reported stable |
| freqChange | input | 1 | Request to change the operating frequency |
| rdReq | input | 1 | Controller issues a read in this cycle |
| dllEnable | output | 1 | DLL-disable line to the memory; low holds the DLL off |
| clkStopReq | output | 1 | Request to halt the memory input clock |
| ready | output | 1 | Commands may be issued |

## Verification
A wrong internal state shows up at the three outputs. `dllEnable` may rise before `clkStable`. A halt request may be missing on the edge after a frequency change. A lock count or calibration count may be cut short or carried over from an earlier attempt, and `ready` then rises early by a number of edges that the bench can measure. Every expected transition has an exact due cycle, counted from the stimulus edge. A counter that is off by one, a calibration count that ignores reads, or a counter that is not cleared on re-entry therefore fails on the first edge where `ready` differs. That edge lies at most a few thousand cycles after the stimulus.

// File: rtl/sram_dll_seq_pkg.sv
package sram_dll_seq_pkg;

  typedef enum logic [2:0] {
    PWR_WAIT   = 3'd0,
    DLL_HOLD   = 3'd1,
    LOCK_COUNT = 3'd2,
    CAL_COUNT  = 3'd3,
    RUN        = 3'd4,
    CLK_HALT   = 3'd5
  } seqState_e;

  typedef struct packed {
    logic lockRun;
    logic calRun;
    logic haltRun;
  } seqStrobe_t;

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic step,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (step && cnt != LAST) begin
      cnt <= cnt + W'(1);
    end
  end

  assign done = run && step && (cnt == LAST);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (run && !step) |=> (cnt == $past(cnt)));  // R4
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!run) |=> (cnt == '0));  // R6

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import sram_dll_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 2048,
  parameter int CAL_CYCLES  = 1024,
  parameter int HALT_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       rdReq,
  output logic       lockDone,
  output logic       calDone,
  output logic       haltDone
);

  seq_counter #(.LIMIT(LOCK_CYCLES)) i_lockCnt (
    .clk  (clk),
    .rstN (rstN),
    .run  (strb.lockRun),
    .step (1'b1),
    .done (lockDone)
  );

  seq_counter #(.LIMIT(CAL_CYCLES)) i_calCnt (
    .clk  (clk),
    .rstN (rstN),
    .run  (strb.calRun),
    .step (!rdReq),
    .done (calDone)
  );

  seq_counter #(.LIMIT(HALT_CYCLES)) i_haltCnt (
    .clk  (clk),
    .rstN (rstN),
    .run  (strb.haltRun),
    .step (1'b1),
    .done (haltDone)
  );

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import sram_dll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       clkStable,
  input  logic       freqChange,
  input  logic       lockDone,
  input  logic       calDone,
  input  logic       haltDone,
  output seqStrobe_t strb,
  output logic       dllEnable,
  output logic       clkStopReq,
  output logic       ready
);

  seqState_e state, nextState;

  always_comb begin
    nextState = state;
    if (!pwrGood) begin
      nextState = PWR_WAIT;
    end else begin
      case (state)
        PWR_WAIT:   nextState = DLL_HOLD;
        DLL_HOLD:   if (clkStable) nextState = LOCK_COUNT;
        LOCK_COUNT: begin
          if (!clkStable || freqChange) nextState = CLK_HALT;
          else if (lockDone)            nextState = CAL_COUNT;
        end
        CAL_COUNT: begin
          if (!clkStable || freqChange) nextState = CLK_HALT;
          else if (calDone)             nextState = RUN;
        end
        RUN:        if (!clkStable || freqChange) nextState = CLK_HALT;
        CLK_HALT:   if (haltDone && clkStable) nextState = LOCK_COUNT;
        default:    nextState = PWR_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PWR_WAIT;
    else       state <= nextState;
  end

  always_comb begin
    strb.lockRun = (state == LOCK_COUNT);
    strb.calRun  = (state == CAL_COUNT);
    strb.haltRun = (state == CLK_HALT);
  end

  assign dllEnable  = (state == LOCK_COUNT) || (state == CAL_COUNT) ||
                      (state == RUN) || (state == CLK_HALT);
  assign clkStopReq = (state == CLK_HALT);
  assign ready      = (state == RUN);

  AST_PWR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrGood) |=> (!dllEnable && !ready && !clkStopReq));  // R8
  AST_FREQ_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && ready && freqChange) |=> clkStopReq);  // R5
  AST_HALT_KEEPS_DLL: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && clkStopReq) |=> dllEnable);  // R5
  AST_DLL_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dllEnable) |-> $past(pwrGood && clkStable));  // R2
  AST_CLK_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && ready && !clkStable) |=> clkStopReq);  // R7

endmodule

// File: rtl/sram_dll_seq.sv
module sram_dll_seq
  import sram_dll_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 2048,
  parameter int CAL_CYCLES  = 1024,
  parameter int HALT_CYCLES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrGood,
  input  logic clkStable,
  input  logic freqChange,
  input  logic rdReq,
  output logic dllEnable,
  output logic clkStopReq,
  output logic ready
);

  seqStrobe_t strb;
  logic lockDone, calDone, haltDone;

  seq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwrGood    (pwrGood),
    .clkStable  (clkStable),
    .freqChange (freqChange),
    .lockDone   (lockDone),
    .calDone    (calDone),
    .haltDone   (haltDone),
    .strb       (strb),
    .dllEnable  (dllEnable),
    .clkStopReq (clkStopReq),
    .ready      (ready)
  );

  seq_datapath #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .CAL_CYCLES  (CAL_CYCLES),
    .HALT_CYCLES (HALT_CYCLES)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdReq    (rdReq),
    .lockDone (lockDone),
    .calDone  (calDone),
    .haltDone (haltDone)
  );

  AST_READY_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(!rdReq));  // R4

endmodule

// File: tb/test_sram_dll_seq.sv
module test_sram_dll_seq;

  localparam int L = 2048;
  localparam int Z = 1024;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrGood = 1'b0, clkStable = 1'b0, freqChange = 1'b0, rdReq = 1'b0;
  logic dllEnable, clkStopReq, ready;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    due;
    logic  dl;
    logic  st;
    logic  rd;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  sram_dll_seq #(.LOCK_CYCLES(L), .CAL_CYCLES(Z), .HALT_CYCLES(S)) i_sram_dll_seq (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .clkStable(clkStable),
    .freqChange(freqChange), .rdReq(rdReq),
    .dllEnable(dllEnable), .clkStopReq(clkStopReq), .ready(ready)
  );

  task automatic finishRun();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL pending: %0d expectations never reached, expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin : monitor
    exp_t e;
    #5;
    cyc++;
    while (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      checks++;
      if (dllEnable !== e.dl || clkStopReq !== e.st || ready !== e.rd) begin
        errors++;
        $display("FAIL %s @%0d: dll=%0b stop=%0b rdy=%0b expected %0b %0b %0b",
                 e.tag, cyc, dllEnable, clkStopReq, ready, e.dl, e.st, e.rd);
      end
    end
  end

  task automatic expectAt(int base, int d, logic dl, logic st, logic rd, string tag);
    exp_t e;
    e.due = base + d; e.dl = dl; e.st = st; e.rd = rd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic waitNeg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic runTo(int abs);
    while (cyc <= abs) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin : driver
    int b;
    waitNeg(3);
    rstN = 1'b1;
    // R1: reset state
    b = cyc; expectAt(b, 1, 0, 0, 0, "R1");
    runTo(b + 1);

    // R2 / R9: power good, clock not yet stable, frequency change ignored
    b = cyc;
    pwrGood = 1'b1;
    expectAt(b, 1, 0, 0, 0, "R2");
    expectAt(b, 4, 0, 0, 0, "R9");
    expectAt(b, 6, 0, 0, 0, "R9");
    waitNeg(3);
    freqChange = 1'b1;
    waitNeg(1);
    freqChange = 1'b0;
    runTo(b + 6);

    // R2 / R3 / R4: bring-up with reads in lock (no effect) and in calibration (7 stalls)
    b = cyc;
    clkStable = 1'b1;
    expectAt(b, 1, 1, 0, 0, "R2");
    expectAt(b, L + Z, 1, 0, 0, "R3");
    expectAt(b, L + Z + 7, 1, 0, 0, "R4");
    expectAt(b, L + Z + 8, 1, 0, 1, "R4");
    waitNeg(99);
    rdReq = 1'b1;
    waitNeg(10);
    rdReq = 1'b0;
    waitNeg(L + 50 - 109);
    rdReq = 1'b1;
    waitNeg(7);
    rdReq = 1'b0;
    runTo(b + L + Z + 8);

    // R5 / R6: frequency change while ready
    b = cyc;
    freqChange = 1'b1;
    expectAt(b, 1, 1, 1, 0, "R5");
    expectAt(b, S, 1, 1, 0, "R6");
    expectAt(b, S + 1, 1, 0, 0, "R6");
    expectAt(b, S + L + Z, 1, 0, 0, "R6");
    expectAt(b, S + L + Z + 1, 1, 0, 1, "R6");
    waitNeg(1);
    freqChange = 1'b0;
    runTo(b + S + L + Z + 1);

    // R7 / R6: clock instability while ready, halt waits for clock
    b = cyc;
    clkStable = 1'b0;
    expectAt(b, 1, 1, 1, 0, "R7");
    expectAt(b, 6, 1, 1, 0, "R6");
    expectAt(b, 7, 1, 0, 0, "R6");
    expectAt(b, 6 + L + Z, 1, 0, 0, "R7");
    expectAt(b, 7 + L + Z, 1, 0, 1, "R7");
    waitNeg(6);
    clkStable = 1'b1;
    runTo(b + 7 + L + Z);

    // R6: second frequency change mid-calibration discards calibration progress
    b = cyc;
    freqChange = 1'b1;
    expectAt(b, L + 100, 1, 0, 0, "R6");
    expectAt(b, L + 101, 1, 1, 0, "R6");
    expectAt(b, 2 * L + Z + 102, 1, 0, 0, "R6");
    expectAt(b, 2 * L + Z + 103, 1, 0, 1, "R6");
    waitNeg(1);
    freqChange = 1'b0;
    waitNeg(L + 99);
    freqChange = 1'b1;
    waitNeg(1);
    freqChange = 1'b0;
    runTo(b + 2 * L + Z + 103);

    // R8: power loss while ready, then restart
    b = cyc;
    pwrGood = 1'b0;
    expectAt(b, 1, 0, 0, 0, "R8");
    expectAt(b, 3, 0, 0, 0, "R8");
    waitNeg(3);
    b = cyc;
    pwrGood = 1'b1;
    expectAt(b, 1, 0, 0, 0, "R8");
    expectAt(b, 2, 1, 0, 0, "R8");
    runTo(b + 2);

    finishRun();
  end

endmodule